// File: doc/BRIEF.md
# Iterative Integer Multiply and Divide Engine

This engine executes the eight integer multiply and divide operations of a 32-bit RISC-V core's M extension over several clock cycles. A caller places an operation code and two operands on the inputs and raises `start_i` for one cycle while the engine is idle. The engine then holds `busy_o` high while it iterates, and raises `done_o` for a single cycle with the result on `result_o`.

Each operation has its own latency. A parameter selects one of two multiplier variants. The fast variant needs a short, fixed number of cycles and consumes half of the multiplier operand per step. The slow variant is a shift-add loop that consumes one multiplier bit per step. For the low-half product it stops as soon as the remaining multiplier bits are zero. Division is a restoring long division of fixed length. A zero divisor makes it finish almost at once.

Top module: `muldiv_iter`

## Requirements
- R1: `op_i` encodes 0 MUL, 1 MULH, 2 MULHSU, 3 MULHU, 4 DIV, 5 DIVU, 6 REM, 7 REMU. When `start_i` is high at a rising edge while `busy_o` is low, that edge accepts the operands and `busy_o` is high in the cycle after it.
- R2: MUL returns the low W bits of the product (W defaults to 32).
- R3: MULH treats both operands as signed, MULHSU treats A as signed and B as unsigned, and MULHU treats both as unsigned. Each returns the upper W bits of the 2W-bit product.
- R4: DIV and REM are signed, and DIVU and REMU are unsigned. Quotients truncate toward zero and a remainder takes the dividend's sign. The most negative value divided by all-ones (-1) gives the dividend as the quotient and zero as the remainder.
- R5: With a zero divisor, DIV and DIVU return all ones, and REM and REMU return the dividend.
- R6: With a stall count S, `done_o` is high in the cycle following the (S+1)-th rising edge after the accepting edge. `busy_o` is high from the accepting edge until that point and is low while `done_o` is high.
- R7: With the fast multiplier, S is 2 for MUL and 3 for MULH, MULHSU and MULHU.
- R8: With the slow multiplier, S for MUL equals the bit length of B (the index of its highest set bit plus one, or 0 when B is zero). S is W for MULH, MULHSU and MULHU.
- R9: Division and remainder take S = W+5 when the divisor is nonzero and S = 1 when it is zero.
- R10: `done_o` is high for exactly one cycle per operation. `result_o` keeps its value until the next completion.
- R11: `start_i` and the operand inputs are ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch request, taken only while idle |
| op_i | input | 3 | Operation code (see R1) |
| a_i | input | W | Operand A: multiplicand or dividend |
| b_i | input | W | Operand B: multiplier or divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | W | Result, valid with `done_o` and held after it |

## Verification
A wrong latch of the sign flags or of the zero-divisor flag at the accepting edge shows up only at completion. It appears as a result that is negated or replaced by the divide-by-zero value, and it surfaces between 2 and W+6 cycles after start. A broken step counter or termination test moves the cycle in which `done_o` rises, so every operation is timed edge by edge on both multiplier variants. Corruption of captured state by a start request during a run is checked by driving new operands mid-division and comparing the completed result.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [2:0] {
        OP_MUL    = 3'd0,
        OP_MULH   = 3'd1,
        OP_MULHSU = 3'd2,
        OP_MULHU  = 3'd3,
        OP_DIV    = 3'd4,
        OP_DIVU   = 3'd5,
        OP_REM    = 3'd6,
        OP_REMU   = 3'd7
    } md_op_e;

endpackage

// File: rtl/muldiv_sign_prep.sv
module muldiv_sign_prep
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  md_op_e         op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   a_mag,
    output logic [W-1:0]   b_mag,
    output logic           prod_neg,
    output logic           rem_neg
);
    logic a_signed, b_signed, a_neg, b_neg;

    always_comb begin
        a_signed = (op == OP_MULH) || (op == OP_MULHSU) || (op == OP_DIV) || (op == OP_REM);
        b_signed = (op == OP_MULH) || (op == OP_DIV) || (op == OP_REM);
        a_neg    = a_signed && a[W-1];
        b_neg    = b_signed && b[W-1];
        a_mag    = a_neg ? -a : a;
        b_mag    = b_neg ? -b : b;
        prod_neg = a_neg ^ b_neg;
        rem_neg  = a_neg;
    end
endmodule

// File: rtl/muldiv_step.sv
module muldiv_step #(
    parameter int W    = 32,
    parameter bit FAST = 1'b1
) (
    input  logic           is_div,
    input  logic [2*W-1:0] mcand,
    input  logic [W-1:0]   mplier,
    input  logic [2*W-1:0] acc,
    output logic [2*W-1:0] mcand_n,
    output logic [W-1:0]   mplier_n,
    output logic [2*W-1:0] acc_n
);
    localparam int H = W / 2;

    logic [2*W-1:0] mul_acc, mul_mcand;
    logic [W-1:0]   mul_mplier;
    logic [2*W-1:0] div_acc;

    generate
        if (FAST) begin : g_fast
            always_comb begin
                mul_acc    = acc + mcand * {{(2*W-H){1'b0}}, mplier[H-1:0]};
                mul_mcand  = mcand << H;
                mul_mplier = mplier >> H;
            end
        end else begin : g_slow
            always_comb begin
                mul_acc    = acc + (mplier[0] ? mcand : '0);
                mul_mcand  = mcand << 1;
                mul_mplier = mplier >> 1;
            end
        end
    endgenerate

    logic [W:0]   trial;
    logic         fits;
    logic [W-1:0] rem_next;

    always_comb begin
        trial    = {acc[2*W-1:W], acc[W-1]};
        fits     = trial >= {1'b0, mcand[W-1:0]};
        rem_next = fits ? W'(trial - {1'b0, mcand[W-1:0]}) : trial[W-1:0];
        div_acc  = {rem_next, acc[W-2:0], fits};
    end

    always_comb begin
        if (is_div) begin
            acc_n    = div_acc;
            mcand_n  = mcand;
            mplier_n = mplier;
        end else begin
            acc_n    = mul_acc;
            mcand_n  = mul_mcand;
            mplier_n = mul_mplier;
        end
    end
endmodule

// File: rtl/muldiv_iter.sv
module muldiv_iter
    import muldiv_pkg::*;
#(
    parameter int W        = 32,
    parameter bit FAST_MUL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [2:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] result_o
);
    localparam int CW         = $clog2(W + 6) + 1;
    localparam int DIV_STALL  = W + 5;
    localparam int FMUL_STEPS = 2;
    localparam int MUL_STEPS  = FAST_MUL ? FMUL_STEPS : W;
    localparam int MULL_STALL = FAST_MUL ? 2 : W;
    localparam int MULH_STALL = FAST_MUL ? 3 : W;

    typedef struct packed {
        logic           busy;
        logic           done;
        logic [CW-1:0]  cnt;
        logic [CW-1:0]  phase;
        md_op_e         op;
        logic [W-1:0]   a_raw;
        logic           b_zero;
        logic           pneg;
        logic           rneg;
        logic [2*W-1:0] mcand;
        logic [W-1:0]   mplier;
        logic [2*W-1:0] acc;
        logic [W-1:0]   res;
    } md_state_t;

    md_state_t q, d;

    md_op_e         op_in;
    logic [W-1:0]   a_mag, b_mag;
    logic           pneg_in, rneg_in;
    logic [2*W-1:0] mcand_n, acc_n;
    logic [W-1:0]   mplier_n;

    assign op_in = md_op_e'(op_i);

    muldiv_sign_prep #(.W(W)) u_prep (
        .op       (op_in),
        .a        (a_i),
        .b        (b_i),
        .a_mag    (a_mag),
        .b_mag    (b_mag),
        .prod_neg (pneg_in),
        .rem_neg  (rneg_in)
    );

    muldiv_step #(.W(W), .FAST(FAST_MUL)) u_step (
        .is_div   (q.op[2]),
        .mcand    (q.mcand),
        .mplier   (q.mplier),
        .acc      (q.acc),
        .mcand_n  (mcand_n),
        .mplier_n (mplier_n),
        .acc_n    (acc_n)
    );

    logic           finish;
    logic [CW-1:0]  step_lim;
    logic [2*W-1:0] prod;
    logic [W-1:0]   quo, rem, final_res;

    always_comb begin
        prod = q.pneg ? -q.acc : q.acc;
        quo  = q.acc[W-1:0];
        rem  = q.acc[2*W-1:W];
        if (!q.op[2]) begin
            final_res = (q.op == OP_MUL) ? prod[W-1:0] : prod[2*W-1:W];
        end else if (q.b_zero) begin
            final_res = q.op[1] ? q.a_raw : '1;
        end else if (!q.op[1]) begin
            final_res = q.pneg ? -quo : quo;
        end else begin
            final_res = q.rneg ? -rem : rem;
        end
    end

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        finish   = 1'b0;
        step_lim = q.op[2] ? CW'(W) : CW'(MUL_STEPS);
        if (!q.busy) begin
            if (start_i) begin
                d.busy   = 1'b1;
                d.op     = op_in;
                d.a_raw  = a_i;
                d.b_zero = (b_i == '0);
                d.pneg   = pneg_in;
                d.rneg   = rneg_in;
                d.phase  = '0;
                if (op_in[2]) begin
                    d.mcand  = {{W{1'b0}}, b_mag};
                    d.mplier = '0;
                    d.acc    = {{W{1'b0}}, a_mag};
                    d.cnt    = (b_i == '0) ? CW'(1) : CW'(DIV_STALL);
                end else begin
                    d.mcand  = {{W{1'b0}}, a_mag};
                    d.mplier = b_mag;
                    d.acc    = '0;
                    d.cnt    = (op_in == OP_MUL) ? CW'(MULL_STALL) : CW'(MULH_STALL);
                end
            end
        end else begin
            if (!FAST_MUL && q.op == OP_MUL) begin
                finish = (q.mplier == '0);
            end else begin
                finish = (q.cnt == '0);
            end
            if (finish) begin
                d.busy = 1'b0;
                d.done = 1'b1;
                d.res  = final_res;
            end else begin
                d.cnt = q.cnt - CW'(1);
                if (q.phase < step_lim) begin
                    d.acc    = acc_n;
                    d.mcand  = mcand_n;
                    d.mplier = mplier_n;
                    d.phase  = q.phase + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o   = q.busy;
    assign done_o   = q.done;
    assign result_o = q.res;

    // Edge counter used only by the latency assertions below.
    logic [CW-1:0] lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (start_i && !busy_o) begin
            lat_q <= '0;
        end else if (busy_o) begin
            lat_q <= lat_q + CW'(1);
        end
    end

    a_r1_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    a_r6_busy_done_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r11_capture_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(q.op) && $stable(q.a_raw) && $stable(q.b_zero)));

    a_r9_div_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && q.op[2] && !q.b_zero) |-> (lat_q == CW'(DIV_STALL + 1)));

    a_r9_div_zero_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && q.op[2] && q.b_zero) |-> (lat_q == CW'(2)));

    a_r5_zero_div_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && q.op[2] && !q.op[1] && q.b_zero) |-> (result_o == '1));

    generate
        if (FAST_MUL) begin : g_fast_chk
            a_r7_fast_mul_latency: assert property (@(posedge clk) disable iff (!rst_n)
                (done_o && !q.op[2]) |-> (lat_q == ((q.op == OP_MUL) ? CW'(3) : CW'(4))));
        end else begin : g_slow_chk
            a_r8_slow_mulh_latency: assert property (@(posedge clk) disable iff (!rst_n)
                (done_o && !q.op[2] && q.op != OP_MUL) |-> (lat_q == CW'(W + 1)));
        end
    endgenerate
endmodule

// File: tb/sim_muldiv_iter.sv
module sim_muldiv_iter;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start_i;
    logic [2:0]   op_i;
    logic [W-1:0] a_i, b_i;
    logic         busy0, done0, busy1, done1;
    logic [W-1:0] res0, res1;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    muldiv_iter #(.W(W), .FAST_MUL(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .busy_o(busy0), .done_o(done0), .result_o(res0));

    muldiv_iter #(.W(W), .FAST_MUL(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .busy_o(busy1), .done_o(done1), .result_o(res1));

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint sx(input int v);
        return (v >= 128) ? longint'(v - 256) : longint'(v);
    endfunction

    function automatic int expect_res(input int op, input int ua, input int ub);
        longint sa = sx(ua);
        longint sb = sx(ub);
        longint r;
        case (op)
            0: r = ua * ub;
            1: r = (sa * sb) >>> 8;
            2: r = (sa * longint'(ub)) >>> 8;
            3: r = (ua * ub) >> 8;
            4: r = (ub == 0) ? 255 : ((ua == 128 && ub == 255) ? 128 : sa / sb);
            5: r = (ub == 0) ? 255 : ua / ub;
            6: r = (ub == 0) ? ua : ((ua == 128 && ub == 255) ? 0 : sa % sb);
            default: r = (ub == 0) ? ua : ua % ub;
        endcase
        return int'(r & 255);
    endfunction

    function automatic int bitlen(input int v);
        int n = 0;
        for (int i = 0; i < W; i++) if (v[i]) n = i + 1;
        return n;
    endfunction

    function automatic int expect_stall(input int op, input int ub, input bit fast);
        if (op >= 4) return (ub == 0) ? 1 : W + 5;
        if (fast) return (op == 0) ? 2 : 3;
        return (op == 0) ? bitlen(ub) : W;
    endfunction

    task automatic run_op(input int op, input int ua, input int ub, input bit disturb);
        int lat0 = 0, lat1 = 0;
        int got0 = 0, got1 = 0;
        int busy_err = 0;
        int pulse_err = 0;
        string rq_res, rq_l0, rq_l1;
        rq_res = (op == 0) ? "R2" : (op < 4) ? "R3" : (ub == 0) ? "R5" : "R4";
        rq_l0  = (op < 4) ? "R8" : "R9";
        rq_l1  = (op < 4) ? "R7" : "R9";
        @(negedge clk);
        start_i = 1'b1; op_i = 3'(op); a_i = W'(ua); b_i = W'(ub);
        @(negedge clk);
        check(busy0 && busy1, "R1", "busy after accept", longint'(busy0 & busy1), 1);
        if (disturb) begin
            start_i = 1'b1; op_i = 3'd0; a_i = '1; b_i = '1;
        end else begin
            start_i = 1'b0;
        end
        for (int k = 1; k < 60; k++) begin
            @(negedge clk);
            if (disturb && k == 5) start_i = 1'b0;
            if (got0 == 0) begin
                if (done0) begin
                    got0 = 1; lat0 = k;
                    check(res0 == W'(expect_res(op, ua, ub)), disturb ? "R11" : rq_res,
                          $sformatf("u0 op%0d a=%0d b=%0d", op, ua, ub),
                          res0, expect_res(op, ua, ub));
                    if (busy0) busy_err++;
                end else if (!busy0) busy_err++;
            end else if (k == lat0 + 1 && done0) pulse_err++;
            if (got1 == 0) begin
                if (done1) begin
                    got1 = 1; lat1 = k;
                    check(res1 == W'(expect_res(op, ua, ub)), disturb ? "R11" : rq_res,
                          $sformatf("u1 op%0d a=%0d b=%0d", op, ua, ub),
                          res1, expect_res(op, ua, ub));
                    if (busy1) busy_err++;
                end else if (!busy1) busy_err++;
            end else if (k == lat1 + 1 && done1) pulse_err++;
            if (got0 != 0 && got1 != 0 && k > lat0 + 1 && k > lat1 + 1) break;
        end
        check(got0 != 0 && got1 != 0, "R6", "completion seen", got0 + got1, 2);
        check(lat0 == expect_stall(op, ub, 1'b0) + 1, rq_l0,
              $sformatf("u0 latency op%0d b=%0d", op, ub), lat0, expect_stall(op, ub, 1'b0) + 1);
        check(lat1 == expect_stall(op, ub, 1'b1) + 1, rq_l1,
              $sformatf("u1 latency op%0d b=%0d", op, ub), lat1, expect_stall(op, ub, 1'b1) + 1);
        check(busy_err == 0, "R6", "busy profile", busy_err, 0);
        check(pulse_err == 0, "R10", "done width", pulse_err, 0);
    endtask

    initial begin
        #(20 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL R6 watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    int a_set[12] = '{0, 1, 2, 7, 37, 100, 127, 128, 129, 200, 254, 255};
    int b_set[16] = '{0, 1, 2, 3, 5, 8, 15, 16, 64, 127, 128, 129, 170, 200, 254, 255};

    initial begin
        rst_n = 1'b0; start_i = 1'b0; op_i = '0; a_i = '0; b_i = '0;
        repeat (3) @(negedge clk);
        check(!busy0 && !done0 && res0 == '0, "R6", "reset state u0", {busy0, done0}, 0);
        check(!busy1 && !done1 && res1 == '0, "R6", "reset state u1", {busy1, done1}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy0 && !busy1, "R1", "idle without start", busy0 | busy1, 0);

        for (int op = 0; op < 8; op++)
            for (int i = 0; i < 12; i++)
                for (int j = 0; j < 16; j++)
                    run_op(op, a_set[i], b_set[j], 1'b0);

        // R11: new request held high during a division must not disturb it
        run_op(4, 100, 7, 1'b1);
        run_op(7, 200, 9, 1'b1);

        // R10: result is held after the pulse
        run_op(0, 13, 11, 1'b0);
        repeat (4) @(negedge clk);
        check(res0 == W'(143) && res1 == W'(143), "R10", "result held", res0, 143);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule